// File: doc/BRIEF.md
# Masked Register Access Responder

This block sits behind a frame receiver on a serial link. It carries out decoded register commands against a bank of 16-bit registers and answers each command with a reply. The reply leaves as a big-endian byte stream meant for a UART transmitter.

Command words arrive one per handshake. The last word of a frame is flagged, and that last word is the trailer. The trailer holds the register or start address in bits 31-16 and an additive checksum in bits 7-0. Once the trailer has been taken, the block checks the frame and decides whether to run it. It can apply a masked single-register write, read one register, write a block of 32-bit words or read one back. A 32-bit word always covers two adjacent registers, the even one in the upper half. The reply echoes the module ID and carries a bit-coded status byte and a checksum of its own.

The block takes commands addressed to its own module ID and to the broadcast ID. Commands for any other ID pass without effect. Broadcasts are carried out but get no reply.

Top module: `reg_access_responder`

## Requirements
- R1: The reply header word carries the command code plus 0x80 in bits 31-24, the received module ID in bits 23-8 and the reply length in words in bits 7-0. A command whose module ID is neither `MY_ID` nor `BCAST_ID` changes no register and produces no reply.
- R2: Command 0x41 has length 3. Word 2 holds the mask in bits 31-16 and the value in bits 15-0. Each register bit whose mask bit is 1 takes the value bit, and every other bit keeps its contents.
- R3: Commands 0x41 and 0x42 (length 2) get a 2-word reply. Word 2 holds the register contents in bits 31-16 (after the write, for 0x41), the status byte in bits 15-8 and the checksum in bits 7-0. Bits 31-16 are zero when the status is not zero.
- R4: Command 0x43 of length N carries N-2 data words (at most `MAXW`) and then the trailer. Data word j goes to register A+2j (bits 31-16) and register A+2j+1 (bits 15-0). The reply has 2 words and its trailer bits 31-16 are zero.
- R5: Command 0x44 has length 3 and holds a word count C in bits 15-0 of word 2. On success the reply has C+2 words, with C data words packed as in R4 and then the status/checksum trailer.
- R6: Reply bytes leave most significant byte first. The final byte is the modulo-256 sum of all reply bytes before it.
- R7: If the modulo-256 sum of every command byte except the last does not equal the last byte, the status is 0x01 (bit 0) and nothing is written.
- R8: Checks run in this order and only the first one that fails is reported: checksum, command code, length, alignment or count, address range, lock. An unknown command code gives status 0x08 (bit 3).
- R9: An access that reaches past the last register gives status 0x10 (bit 4) and writes nothing.
- R10: A write that touches a locked register gives status 0x40 (bit 6) and writes nothing at all. By default register 15 is locked.
- R11: Each of the following gives status 0x20 (bit 5) and writes nothing: a length field that disagrees with the received word count or with the command's fixed length, an odd start address on 0x43 or 0x44, and a read count of 0 or above `MAXW`.
- R12: No reply byte is offered before the whole command frame has been taken. `cmd_ready_o` is low from the cycle after the trailer until the last reply byte is accepted.
- R13: A command with module ID `BCAST_ID` (0x00FF) is carried out but sends no reply.
- R14: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_byte_o` and `tx_valid_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word offered |
| cmd_word_i | input | 32 | Command word |
| cmd_last_i | input | 1 | Offered word is the frame trailer |
| cmd_ready_o | output | 1 | Command word is taken this cycle if valid |
| tx_valid_o | output | 1 | Reply byte offered |
| tx_byte_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Transmitter takes the reply byte |

## Verification
Two functions can land in the same cycle. One is the hand-off of the last reply byte. The other is the offer of the first word of the next command. The bench provokes this by driving the next frame while the previous reply is still draining under a stalling ready pattern. It judges the result by requiring both replies to come back byte-exact: a word taken during the reply would corrupt the second frame, and a byte lost would corrupt the first. The masked-write sweep runs the mask and value patterns over every writable register, and each write is answered with the merged value. This makes the status-priority chain and the write data path meet in every reply.

// File: rtl/rar_pkg.sv
package rar_pkg;

  localparam logic [7:0] OP_REG_WR = 8'h41;
  localparam logic [7:0] OP_REG_RD = 8'h42;
  localparam logic [7:0] OP_BLK_WR = 8'h43;
  localparam logic [7:0] OP_BLK_RD = 8'h44;
  localparam logic [7:0] REPLY_TAG = 8'h80;

  localparam int ST_CSUM = 0;
  localparam int ST_CMD  = 3;
  localparam int ST_ADDR = 4;
  localparam int ST_PROC = 5;
  localparam int ST_LOCK = 6;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WRITE, S_REPLY} rar_state_e;

  // sum of the four bytes of a word, modulo 256
  function automatic logic [7:0] word_byte_sum(input logic [31:0] w);
    return w[31:24] + w[23:16] + w[15:8] + w[7:0];
  endfunction

  // sum of the three bytes of a trailer that precede its checksum byte
  function automatic logic [7:0] trailer_byte_sum(input logic [31:0] w);
    return w[31:24] + w[23:16] + w[15:8];
  endfunction

  function automatic logic [15:0] masked_merge(input logic [15:0] old_v,
                                               input logic [15:0] new_v,
                                               input logic [15:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/rar_frame_rx.sv
module rar_frame_rx #(
  parameter int MAXW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_en,
  input  logic                 word_valid,
  input  logic [31:0]          word,
  input  logic                 word_last,
  output logic                 word_ready,
  output logic                 frame_done,
  output logic [31:0]          hdr,
  output logic [15:0]          addr,
  output logic [MAXW-1:0][31:0] data,
  output logic [7:0]           n_words,
  output logic                 overflow,
  output logic                 csum_ok
);
  import rar_pkg::*;

  logic [7:0] cnt;
  logic [7:0] sum;
  logic       fire;

  assign word_ready = accept_en;
  assign fire       = word_valid && accept_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      sum        <= '0;
      frame_done <= 1'b0;
      hdr        <= '0;
      addr       <= '0;
      n_words    <= '0;
      overflow   <= 1'b0;
      csum_ok    <= 1'b0;
      data       <= '0;
    end else begin
      frame_done <= fire && word_last;
      if (fire) begin
        if (word_last) begin
          cnt     <= '0;
          n_words <= (cnt == 8'hFF) ? 8'hFF : cnt + 8'd1;
          addr    <= word[31:16];
          csum_ok <= (((cnt == 8'd0) ? 8'd0 : sum) + trailer_byte_sum(word)) == word[7:0];
          if (cnt == 8'd0) begin
            hdr      <= word;
            overflow <= 1'b0;
          end
        end else begin
          cnt <= (cnt == 8'hFF) ? cnt : cnt + 8'd1;
          if (cnt == 8'd0) begin
            hdr      <= word;
            sum      <= word_byte_sum(word);
            overflow <= 1'b0;
          end else begin
            sum <= sum + word_byte_sum(word);
            if (cnt > 8'(MAXW)) overflow <= 1'b1;
          end
          for (int i = 0; i < MAXW; i++) begin
            if (cnt == 8'(i + 1)) data[i] <= word;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rar_reg_bank.sv
module rar_reg_bank #(
  parameter int              NREG = 16,
  parameter logic [NREG-1:0] LOCK = '0,
  localparam int             IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [15:0]   wr_val,
  input  logic [15:0]   wr_mask,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [15:0]   rd_a,
  output logic [15:0]   rd_b
);
  import rar_pkg::*;

  logic [15:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && wr_idx == IW'(i) && !LOCK[i])
          regs[i] <= masked_merge(regs[i], wr_val, wr_mask);
      end
    end
  end

  assign rd_a = regs[rd_a_idx];
  assign rd_b = regs[rd_b_idx];

endmodule

// File: rtl/rar_reply_tx.sv
module rar_reply_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  n_words,
  input  logic [31:0] word_in,
  input  logic        tx_ready,
  output logic [7:0]  word_idx,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        done
);
  logic       busy;
  logic [1:0] bsel;
  logic [7:0] sum;
  logic [7:0] cur;
  logic       last_byte;

  always_comb begin
    case (bsel)
      2'd0:    cur = word_in[31:24];
      2'd1:    cur = word_in[23:16];
      2'd2:    cur = word_in[15:8];
      default: cur = word_in[7:0];
    endcase
  end

  assign last_byte = (word_idx == n_words - 8'd1) && (bsel == 2'd3);
  assign tx_byte   = last_byte ? sum : cur;
  assign tx_valid  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bsel     <= '0;
      word_idx <= '0;
      sum      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        bsel     <= '0;
        word_idx <= '0;
        sum      <= '0;
      end else if (busy && tx_ready) begin
        sum <= sum + tx_byte;
        if (last_byte) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bsel <= bsel + 2'd1;
          if (bsel == 2'd3) word_idx <= word_idx + 8'd1;
        end
      end
    end
  end

endmodule

// File: rtl/reg_access_responder.sv
module reg_access_responder #(
  parameter int              NREG      = 16,
  parameter int              MAXW      = 4,
  parameter logic [15:0]     MY_ID     = 16'h0022,
  parameter logic [15:0]     BCAST_ID  = 16'h00FF,
  parameter logic [NREG-1:0] LOCK_MASK = NREG'(1) << (NREG - 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid_i,
  input  logic [31:0] cmd_word_i,
  input  logic        cmd_last_i,
  output logic        cmd_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_byte_o,
  input  logic        tx_ready_i
);
  import rar_pkg::*;

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  rar_state_e state, nxt;

  // frame receiver outputs
  logic                  accept_en, frame_done;
  logic [31:0]           rx_hdr;
  logic [15:0]           rx_addr;
  logic [MAXW-1:0][31:0] rx_data;
  logic [7:0]            rx_nwords;
  logic                  rx_ovf, rx_csum_ok;

  assign accept_en = (state == S_IDLE) && !frame_done;

  rar_frame_rx #(.MAXW(MAXW)) u_rx (
    .clk(clk), .rst_n(rst_n), .accept_en(accept_en),
    .word_valid(cmd_valid_i), .word(cmd_word_i), .word_last(cmd_last_i),
    .word_ready(cmd_ready_o), .frame_done(frame_done),
    .hdr(rx_hdr), .addr(rx_addr), .data(rx_data), .n_words(rx_nwords),
    .overflow(rx_ovf), .csum_ok(rx_csum_ok)
  );

  // decode of the held frame
  logic [7:0]  op_c, len_c, nblk_c;
  logic [15:0] mod_c, rdcnt_c;
  logic        is_bcast_c, is_target_c, known_c, len_ok_c, is_blk_c, is_wr_c;
  logic [17:0] span_c, end_c;
  logic        range_ok_c;
  logic [NREG-1:0] lock_bits;
  logic [7:0]  status_c, wr_total_c, reply_len_c;

  assign op_c        = rx_hdr[31:24];
  assign mod_c       = rx_hdr[23:8];
  assign len_c       = rx_hdr[7:0];
  assign nblk_c      = len_c - 8'd2;
  assign rdcnt_c     = rx_data[0][15:0];
  assign is_bcast_c  = (mod_c == BCAST_ID);
  assign is_target_c = (mod_c == MY_ID) || is_bcast_c;
  assign known_c     = (op_c == OP_REG_WR) || (op_c == OP_REG_RD) ||
                       (op_c == OP_BLK_WR) || (op_c == OP_BLK_RD);
  assign is_blk_c    = (op_c == OP_BLK_WR) || (op_c == OP_BLK_RD);
  assign is_wr_c     = (op_c == OP_REG_WR) || (op_c == OP_BLK_WR);

  always_comb begin
    case (op_c)
      OP_REG_WR: len_ok_c = (len_c == 8'd3);
      OP_REG_RD: len_ok_c = (len_c == 8'd2);
      OP_BLK_RD: len_ok_c = (len_c == 8'd3);
      default:   len_ok_c = (len_c >= 8'd3) && (nblk_c <= 8'(MAXW));
    endcase
    len_ok_c = len_ok_c && (len_c == rx_nwords) && !rx_ovf;
  end

  always_comb begin
    case (op_c)
      OP_BLK_WR: span_c = 18'({nblk_c, 1'b0});
      OP_BLK_RD: span_c = 18'({rdcnt_c, 1'b0});
      default:   span_c = 18'd1;
    endcase
  end

  assign end_c      = 18'(rx_addr) + span_c;
  assign range_ok_c = end_c <= 18'(NREG);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_lock
    assign lock_bits[gi] = LOCK_MASK[gi] && (18'(gi) >= 18'(rx_addr)) && (18'(gi) < end_c);
  end

  always_comb begin
    status_c = '0;
    if (!rx_csum_ok)                                       status_c[ST_CSUM] = 1'b1;
    else if (!known_c)                                     status_c[ST_CMD]  = 1'b1;
    else if (!len_ok_c)                                    status_c[ST_PROC] = 1'b1;
    else if (is_blk_c && rx_addr[0])                       status_c[ST_PROC] = 1'b1;
    else if (op_c == OP_BLK_RD &&
             (rdcnt_c == 16'd0 || rdcnt_c > 16'(MAXW)))    status_c[ST_PROC] = 1'b1;
    else if (!range_ok_c)                                  status_c[ST_ADDR] = 1'b1;
    else if (is_wr_c && |lock_bits)                        status_c[ST_LOCK] = 1'b1;
  end

  always_comb begin
    wr_total_c = '0;
    if (status_c == 8'd0) begin
      if (op_c == OP_REG_WR)      wr_total_c = 8'd1;
      else if (op_c == OP_BLK_WR) wr_total_c = {nblk_c[6:0], 1'b0};
    end
  end

  assign reply_len_c = (op_c == OP_BLK_RD && status_c == 8'd0) ? rdcnt_c[7:0] + 8'd2 : 8'd2;

  // registered command context
  logic [7:0]  op_q, status_q, reply_len_q, wr_total_q, k_q;
  logic [15:0] mod_q, addr_q, val_q, mask_q;
  logic        bcast_q;

  // internal events, named for the checker
  logic            tx_start, tx_done, wr_en, blk_wr_active;
  logic [IW-1:0]   wr_idx;
  logic [15:0]     wr_val, wr_mask;

  always_comb begin
    nxt      = state;
    tx_start = 1'b0;
    case (state)
      S_IDLE:  if (frame_done) nxt = S_EVAL;
      S_EVAL: begin
        if (!is_target_c)            nxt = S_IDLE;
        else if (wr_total_c != 8'd0) nxt = S_WRITE;
        else if (is_bcast_c)         nxt = S_IDLE;
        else begin
          tx_start = 1'b1;
          nxt      = S_REPLY;
        end
      end
      S_WRITE: begin
        if (k_q == wr_total_q - 8'd1) begin
          if (bcast_q) nxt = S_IDLE;
          else begin
            tx_start = 1'b1;
            nxt      = S_REPLY;
          end
        end
      end
      default: if (tx_done) nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= '0;
      status_q    <= '0;
      reply_len_q <= 8'd2;
      wr_total_q  <= '0;
      k_q         <= '0;
      mod_q       <= '0;
      addr_q      <= '0;
      val_q       <= '0;
      mask_q      <= '0;
      bcast_q     <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_EVAL) begin
        op_q        <= op_c;
        status_q    <= status_c;
        reply_len_q <= reply_len_c;
        wr_total_q  <= wr_total_c;
        k_q         <= '0;
        mod_q       <= mod_c;
        addr_q      <= rx_addr;
        val_q       <= rx_data[0][15:0];
        mask_q      <= rx_data[0][31:16];
        bcast_q     <= is_bcast_c;
      end else if (state == S_WRITE) begin
        k_q <= k_q + 8'd1;
      end
    end
  end

  // write path: one register per cycle
  logic [31:0] blk_word;
  always_comb begin
    blk_word = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (k_q[7:1] == 7'(i)) blk_word = rx_data[i];
    end
  end

  assign wr_en         = (state == S_WRITE);
  assign wr_idx        = IW'(addr_q + 16'(k_q));
  assign wr_val        = (op_q == OP_REG_WR) ? val_q : (k_q[0] ? blk_word[15:0] : blk_word[31:16]);
  assign wr_mask       = (op_q == OP_REG_WR) ? mask_q : 16'hFFFF;
  assign blk_wr_active = wr_en && (op_q == OP_BLK_WR);

  // reply path
  logic [7:0]    tx_widx;
  logic [31:0]   reply_word;
  logic [15:0]   rd_a, rd_b, rd_base, upper;
  logic [IW-1:0] rd_a_idx, rd_b_idx;

  assign rd_base  = (op_q == OP_BLK_RD) ? addr_q + 16'({tx_widx - 8'd1, 1'b0}) : addr_q;
  assign rd_a_idx = IW'(rd_base);
  assign rd_b_idx = rd_a_idx + IW'(1);
  assign upper    = (status_q == 8'd0 && (op_q == OP_REG_WR || op_q == OP_REG_RD)) ? rd_a : 16'h0000;

  always_comb begin
    if (tx_widx == 8'd0)                     reply_word = {op_q + REPLY_TAG, mod_q, reply_len_q};
    else if (tx_widx == reply_len_q - 8'd1)  reply_word = {upper, status_q, 8'h00};
    else                                     reply_word = {rd_a, rd_b};
  end

  rar_reg_bank #(.NREG(NREG), .LOCK(LOCK_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_val(wr_val), .wr_mask(wr_mask), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  rar_reply_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .n_words(reply_len_q),
    .word_in(reply_word), .tx_ready(tx_ready_i), .word_idx(tx_widx),
    .tx_valid(tx_valid_o), .tx_byte(tx_byte_o), .done(tx_done)
  );

endmodule

// File: rtl/rar_checker.sv
module rar_checker #(
  parameter int              NREG      = 16,
  parameter int              IW        = 4,
  parameter logic [NREG-1:0] LOCK_MASK = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready_o,
  input logic          tx_valid_o,
  input logic [7:0]    tx_byte_o,
  input logic          tx_ready_i,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          csum_ok,
  input logic          blk_wr_active,
  input logic          addr_lsb,
  input logic          bcast_q
);

  // R12
  reply_while_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> !cmd_ready_o);

  // R10
  no_locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !LOCK_MASK[wr_idx]);

  // R7
  no_write_on_bad_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> csum_ok);

  // R11
  aligned_block_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr_active |-> !addr_lsb);

  // R13
  broadcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> !bcast_q);

  // R14
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

endmodule

bind reg_access_responder rar_checker #(
  .NREG(NREG), .IW(IW), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready_o(cmd_ready_o), .tx_valid_o(tx_valid_o),
  .tx_byte_o(tx_byte_o), .tx_ready_i(tx_ready_i), .wr_en(wr_en), .wr_idx(wr_idx),
  .csum_ok(rx_csum_ok), .blk_wr_active(blk_wr_active), .addr_lsb(addr_q[0]),
  .bcast_q(bcast_q)
);

// File: tb/sim_reg_access_responder.sv
module sim_reg_access_responder;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] ME         = 16'h0022;
  localparam logic [15:0] ALL        = 16'h00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic        cmd_last_i = 1'b0;
  logic        cmd_ready_o;
  logic        tx_valid_o;
  logic [7:0]  tx_byte_o;
  logic        tx_ready_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [31:0] fr [8];
  logic [31:0] ew [8];
  logic [7:0]  rb [40];
  logic [15:0] sh [16];
  logic [7:0]  stall_pat = 8'b1011_0111;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reg_access_responder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
    .cmd_last_i(cmd_last_i), .cmd_ready_o(cmd_ready_o), .tx_valid_o(tx_valid_o),
    .tx_byte_o(tx_byte_o), .tx_ready_i(tx_ready_i)
  );

  // send fr[0..n-1]; the last byte becomes the additive sum (plus one if bad)
  task automatic send(input int n, input bit bad, input bit quiet_chk);
    logic [7:0] s = 8'd0;
    bit noisy = 1'b0;
    for (int i = 0; i < n; i++)
      for (int b = 3; b >= 0; b--)
        if (!(i == n - 1 && b == 0)) s = s + fr[i][8*b +: 8];
    fr[n-1][7:0] = bad ? s + 8'd1 : s;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid_i = 1'b1;
      cmd_word_i  = fr[i];
      cmd_last_i  = (i == n - 1);
      while (!cmd_ready_o) @(negedge clk);
      if (tx_valid_o) noisy = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid_i = 1'b0;
    cmd_last_i  = 1'b0;
    if (quiet_chk) begin
      checks++;
      if (noisy) begin
        fails++;
        $display("FAIL R12 reply byte during frame: got tx_valid=1 exp 0");
      end
    end
  endtask

  task automatic expect_reply(input string tag, input int nw, input bit tail_chk);
    logic [7:0] eb [40];
    logic [7:0] s = 8'd0;
    int got = 0;
    int tmo = 0;
    int bad = -1;
    bit extra = 1'b0;
    for (int i = 0; i < nw * 4; i++) begin
      eb[i] = ew[i/4][8*(3 - i%4) +: 8];
      if (i == nw * 4 - 1) eb[i] = s;
      else s = s + eb[i];
    end
    while (got < nw * 4 && tmo < 2000) begin
      @(negedge clk);
      tx_ready_i = stall_pat[tmo % 8];
      if (tx_valid_o && tx_ready_i) begin
        rb[got] = tx_byte_o;
        got++;
      end
      tmo++;
    end
    @(negedge clk);
    tx_ready_i = 1'b0;
    if (tail_chk) begin
      repeat (6) begin
        @(negedge clk);
        if (tx_valid_o) extra = 1'b1;
      end
    end
    for (int i = 0; i < got; i++)
      if (bad < 0 && rb[i] !== eb[i]) bad = i;
    checks++;
    if (got != nw * 4) begin
      fails++;
      $display("FAIL %s reply bytes got %0d exp %0d", tag, got, nw * 4);
    end else if (bad >= 0) begin
      fails++;
      $display("FAIL %s reply byte %0d got %02h exp %02h", tag, bad, rb[bad], eb[bad]);
    end else if (extra) begin
      fails++;
      $display("FAIL %s extra reply byte got tx_valid=1 exp 0", tag);
    end
  endtask

  task automatic expect_silence(input string tag);
    bit seen = 1'b0;
    tx_ready_i = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (tx_valid_o) seen = 1'b1;
    end
    tx_ready_i = 1'b0;
    checks++;
    if (seen) begin
      fails++;
      $display("FAIL %s reply seen got tx_valid=1 exp 0", tag);
    end
  endtask

  task automatic reg_read(input logic [15:0] a, input logic [15:0] expv, input logic [7:0] st,
                          input string tag);
    fr[0] = {8'h42, ME, 8'd2};
    fr[1] = {a, 16'h0000};
    send(2, 1'b0, 1'b1);
    ew[0] = {8'hC2, ME, 8'd2};
    ew[1] = {(st == 8'd0) ? expv : 16'h0000, st, 8'h00};
    expect_reply(tag, 2, 1'b1);
  endtask

  task automatic reg_write(input logic [15:0] id, input logic [15:0] a, input logic [15:0] m,
                           input logic [15:0] v, input bit bad, input logic [7:0] st,
                           input string tag);
    fr[0] = {8'h41, id, 8'd3};
    fr[1] = {m, v};
    fr[2] = {a, 16'h0000};
    send(3, bad, 1'b1);
    if (st == 8'd0 && (id == ME || id == ALL))
      sh[a[3:0]] = (sh[a[3:0]] & ~m) | (v & m);
    if (id == ME) begin
      ew[0] = {8'hC1, ME, 8'd2};
      ew[1] = {(st == 8'd0) ? sh[a[3:0]] : 16'h0000, st, 8'h00};
      expect_reply(tag, 2, 1'b1);
    end else begin
      expect_silence(tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) sh[i] = 16'h0000;
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_ready_o !== 1'b0 && tx_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset state got tx_valid=%b exp 0", tx_valid_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cmd_ready_o !== 1'b1 || tx_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R12 after reset got ready=%b valid=%b exp 1 0", cmd_ready_o, tx_valid_o);
    end

    // R2 R3 R1 R6: masked write sweep over every writable register
    for (int r = 0; r < 15; r++) begin
      for (int p = 0; p < 3; p++) begin
        logic [15:0] m, v;
        m = (16'h00FF << (p * 4)) ^ 16'(r * 16'h0111);
        v = 16'hC3A5 ^ 16'(r << p) ^ 16'(p * 16'h2492);
        reg_write(ME, 16'(r), m, v, 1'b0, 8'h00, "R2 masked write");
      end
    end
    // R3: read back every register
    for (int r = 0; r < 16; r++) reg_read(16'(r), sh[r], 8'h00, "R3 register read");

    // R10: locked register 15
    reg_write(ME, 16'd15, 16'hFFFF, 16'h1234, 1'b0, 8'h40, "R10 locked write");
    reg_read(16'd15, 16'h0000, 8'h00, "R10 locked unchanged");

    // R7: bad command checksum
    reg_write(ME, 16'd3, 16'hFFFF, 16'h5A5A, 1'b1, 8'h01, "R7 bad checksum");
    reg_read(16'd3, sh[3], 8'h00, "R7 unchanged");

    // R8: unknown command code
    fr[0] = {8'h47, ME, 8'd2};
    fr[1] = {16'h0001, 16'h0000};
    send(2, 1'b0, 1'b1);
    ew[0] = {8'hC7, ME, 8'd2};
    ew[1] = {16'h0000, 8'h08, 8'h00};
    expect_reply("R8 unknown code", 2, 1'b1);

    // R9: address past the bank
    reg_read(16'd16, 16'h0000, 8'h10, "R9 read out of range");
    reg_write(ME, 16'h0020, 16'hFFFF, 16'h0001, 1'b0, 8'h10, "R9 write out of range");

    // R4: block write of 3 words at 4
    fr[0] = {8'h43, ME, 8'd5};
    fr[1] = 32'hA5A5_FFFF; fr[2] = 32'h1357_9BDF; fr[3] = 32'h0F0F_8001;
    fr[4] = {16'd4, 16'h0000};
    send(5, 1'b0, 1'b1);
    for (int j = 0; j < 3; j++) begin
      sh[4 + 2*j]     = fr[1 + j][31:16];
      sh[4 + 2*j + 1] = fr[1 + j][15:0];
    end
    ew[0] = {8'hC3, ME, 8'd2};
    ew[1] = 32'h0000_0000;
    expect_reply("R4 block write", 2, 1'b1);

    // R5: block reads of several sizes
    for (int c = 1; c <= 4; c++) begin
      fr[0] = {8'h44, ME, 8'd3};
      fr[1] = {16'h0000, 16'(c)};
      fr[2] = {16'd4, 16'h0000};
      send(3, 1'b0, 1'b1);
      ew[0] = {8'hC4, ME, 8'(c + 2)};
      for (int j = 0; j < c; j++) ew[1 + j] = {sh[4 + 2*j], sh[5 + 2*j]};
      ew[c + 1] = 32'h0000_0000;
      expect_reply("R5 block read", c + 2, 1'b1);
    end

    // R11: odd block write address
    fr[0] = {8'h43, ME, 8'd3};
    fr[1] = 32'hDEAD_BEEF;
    fr[2] = {16'd5, 16'h0000};
    send(3, 1'b0, 1'b1);
    ew[0] = {8'hC3, ME, 8'd2};
    ew[1] = {16'h0000, 8'h20, 8'h00};
    expect_reply("R11 odd block write", 2, 1'b1);
    reg_read(16'd5, sh[5], 8'h00, "R11 unchanged");
    // R11: read counts 0 and 5, odd read address
    for (int t = 0; t < 3; t++) begin
      fr[0] = {8'h44, ME, 8'd3};
      fr[1] = {16'h0000, (t == 0) ? 16'd0 : (t == 1) ? 16'd5 : 16'd1};
      fr[2] = {(t == 2) ? 16'd3 : 16'd0, 16'h0000};
      send(3, 1'b0, 1'b1);
      ew[0] = {8'hC4, ME, 8'd2};
      ew[1] = {16'h0000, 8'h20, 8'h00};
      expect_reply("R11 bad block read", 2, 1'b1);
    end
    // R11: length field disagrees with received words
    fr[0] = {8'h43, ME, 8'd4};
    fr[1] = 32'h1111_2222; fr[2] = 32'h3333_4444; fr[3] = 32'h5555_6666;
    fr[4] = {16'd0, 16'h0000};
    send(5, 1'b0, 1'b1);
    ew[0] = {8'hC3, ME, 8'd2};
    ew[1] = {16'h0000, 8'h20, 8'h00};
    expect_reply("R11 length mismatch", 2, 1'b1);
    reg_read(16'd0, sh[0], 8'h00, "R11 length unchanged");

    // R10: block write reaching the locked register
    fr[0] = {8'h43, ME, 8'd3};
    fr[1] = 32'h7777_8888;
    fr[2] = {16'd14, 16'h0000};
    send(3, 1'b0, 1'b1);
    ew[0] = {8'hC3, ME, 8'd2};
    ew[1] = {16'h0000, 8'h40, 8'h00};
    expect_reply("R10 locked block", 2, 1'b1);
    reg_read(16'd14, sh[14], 8'h00, "R10 block unchanged");

    // R13: broadcast executes silently
    reg_write(ALL, 16'd2, 16'hFFFF, 16'hB00C, 1'b0, 8'h00, "R13 broadcast silent");
    reg_read(16'd2, sh[2], 8'h00, "R13 broadcast applied");

    // R1: foreign module id ignored
    reg_write(16'h0023, 16'd2, 16'hFFFF, 16'h0000, 1'b0, 8'h00, "R1 foreign id silent");
    reg_read(16'd2, sh[2], 8'h00, "R1 foreign id no effect");

    // R12: next frame offered while the previous reply drains
    fr[0] = {8'h42, ME, 8'd2};
    fr[1] = {16'd6, 16'h0000};
    send(2, 1'b0, 1'b1);
    ew[0] = {8'hC2, ME, 8'd2};
    ew[1] = {sh[6], 8'h00, 8'h00};
    fork
      expect_reply("R12 first reply", 2, 1'b0);
      begin
        fr[0] = {8'h41, ME, 8'd3};
        fr[1] = {16'h0F0F, 16'hFFFF};
        fr[2] = {16'd7, 16'h0000};
        send(3, 1'b0, 1'b0);
      end
    join
    sh[7] = (sh[7] & ~16'h0F0F) | 16'h0F0F;
    ew[0] = {8'hC1, ME, 8'd2};
    ew[1] = {sh[7], 8'h00, 8'h00};
    expect_reply("R12 second reply", 2, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule